// File: doc/BRIEF.md
# SMBus Command Status and Poll Gate

This block sits between a register interface and an SMBus byte engine. It tracks the outcome of manual read and write commands and of hardware-started polling of memory-module thermal sensors. It also decides, cycle by cycle, whether the engine may start a new transaction. Four status flags are kept: read-data-valid, write-done, error and busy. A sticky overrun flag records a manual command that was refused. Polls step through a ring of sensor slots, and the slot index advances only on a poll that completes without error.

A latched error stops the hardware polling and freezes the slot index. Manual commands still run, and each accepted manual command clears the error. The busy flag lives in a flop that only a cold reset clears, so after a warm reset software can see that a transaction was cut short.

The engine is told to begin with a one-cycle `eng_start` and an operation code on `eng_op`. It reports the end of the transaction with `eng_done`, qualified by `eng_nack`.

Top module: `smb_status_gate`

## Requirements
- R1: `rd_valid` rises the cycle after a read (`eng_op` = 2'b01) completes with `eng_done` high and `eng_nack` low. It falls the cycle after a read is started.
- R2: `wr_done` rises the cycle after a write (`eng_op` = 2'b10) completes without NACK. It falls the cycle after a write is started.
- R3: A completion with `eng_nack` high sets `err`, whether the transaction was a read, a write or a poll.
- R4: While `err` is set, no poll (`eng_op` = 2'b11) is started and `poll_slot` does not change.
- R5: An accepted manual command starts even while `err` is set, and it clears `err` in the next cycle.
- R6: `busy` is high from the cycle after `eng_start` until the cycle after a completion. `eng_done` has no effect while `busy` is low.
- R7: `soft_rst` clears `busy` in the next cycle, and no command or poll starts in a cycle where `soft_rst` is high.
- R8: `busy` keeps its value through a warm reset (`warm_rst_n` low). Only `cold_rst_n` low clears it. A transaction cut across a warm reset still completes normally afterwards.
- R9: A poll starts only when `poll_en` is high and `err`, `busy`, `rd_issue`, `wr_issue` and `soft_rst` are all low. If read and write are both issued in the same cycle, the read starts and the write is dropped.
- R10: `poll_slot` advances by one on each poll that completes without NACK, and wraps from NUM_SLOTS-1 to 0.
- R11: A manual issue while `busy` is high starts nothing and sets `overrun`. Once set, `overrun` stays high until a reset.
- R12: A warm or cold reset clears `rd_valid`, `wr_done`, `err`, `overrun` and `poll_slot`. No start occurs while either reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; leaves busy alone |
| soft_rst | input | 1 | Abort request; clears busy |
| poll_en | input | 1 | Enables hardware thermal-sensor polling |
| rd_issue | input | 1 | Manual read command strobe |
| wr_issue | input | 1 | Manual write command strobe |
| eng_done | input | 1 | Engine reports the end of the current transaction |
| eng_nack | input | 1 | Qualifies eng_done: the acknowledge slot saw a NACK |
| eng_start | output | 1 | One-cycle start to the engine |
| eng_op | output | 2 | Operation being started: 01 read, 10 write, 11 poll, 00 none |
| poll_slot | output | $clog2(NUM_SLOTS) | Sensor slot addressed by the next poll |
| rd_valid | output | 1 | Read data valid |
| wr_done | output | 1 | Write finished |
| err | output | 1 | Latched NACK error |
| busy | output | 1 | Transaction in flight (sticky over warm reset) |
| overrun | output | 1 | A manual command was refused while busy |

## Verification
The bench builds the block with NUM_SLOTS set to 5. This is not a power of two, so the slot index must wrap by compare rather than by overflow. The wrap is reached after a few polls and shows the explicit return to zero. The slot width of 3 bits also leaves codes 5 to 7 unused, and the bench watches that the index never reaches them. Because the bench models the engine's done and NACK pulses directly, it can place NACKs on polls and on manual commands, issue strobes while busy, and drop stray completions and resets in the middle of a transaction.

// File: rtl/smb_status_gate.sv
module smb_status_gate #(
  parameter int NUM_SLOTS = 8,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst_n,
  input  logic          soft_rst,
  input  logic          poll_en,
  input  logic          rd_issue,
  input  logic          wr_issue,
  input  logic          eng_done,
  input  logic          eng_nack,
  output logic          eng_start,
  output logic [1:0]    eng_op,
  output logic [SW-1:0] poll_slot,
  output logic          rd_valid,
  output logic          wr_done,
  output logic          err,
  output logic          busy,
  output logic          overrun
);
  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;
  localparam logic [1:0] OP_POLL = 2'b11;
  localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

  logic [1:0] cur_op;

  wire rst_any = !cold_rst_n || !warm_rst_n;
  wire manual  = rd_issue || wr_issue;
  wire open_gate = !rst_any && !soft_rst && !busy;
  wire accept  = open_gate && manual;
  wire poll_go = open_gate && !manual && poll_en && !err;
  wire finish  = busy && eng_done && !soft_rst;
  wire fin_ok  = finish && !eng_nack;

  assign eng_start = accept || poll_go;
  assign eng_op    = !eng_start ? OP_NONE :
                     rd_issue   ? OP_RD   :
                     wr_issue   ? OP_WR   : OP_POLL;

  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      busy   <= 1'b0;
      cur_op <= OP_NONE;
    end else if (warm_rst_n) begin
      if (soft_rst) begin
        busy   <= 1'b0;
        cur_op <= OP_NONE;
      end else if (eng_start) begin
        busy   <= 1'b1;
        cur_op <= eng_op;
      end else if (finish) begin
        busy   <= 1'b0;
        cur_op <= OP_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      rd_valid  <= 1'b0;
      wr_done   <= 1'b0;
      err       <= 1'b0;
      overrun   <= 1'b0;
      poll_slot <= '0;
    end else begin
      if (eng_start && eng_op == OP_RD)   rd_valid <= 1'b0;
      else if (fin_ok && cur_op == OP_RD) rd_valid <= 1'b1;

      if (eng_start && eng_op == OP_WR)   wr_done <= 1'b0;
      else if (fin_ok && cur_op == OP_WR) wr_done <= 1'b1;

      if (accept)                  err <= 1'b0;
      else if (finish && eng_nack) err <= 1'b1;

      if (manual && busy && !soft_rst) overrun <= 1'b1;

      if (fin_ok && cur_op == OP_POLL)
        poll_slot <= (poll_slot == LAST) ? '0 : poll_slot + 1'b1;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst_any)
    eng_start |-> !busy); // R6
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst_any)
    eng_start |=> busy); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst_any)
    (busy && eng_done && !soft_rst) |=> !busy); // R6
  AST_SOFT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst_any)
    soft_rst |=> !busy); // R7
  AST_ERR_FREEZES_SLOT: assert property (@(posedge clk) disable iff (rst_any)
    err |=> $stable(poll_slot)); // R4
  AST_MANUAL_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst_any)
    (eng_start && eng_op != OP_POLL) |=> !err); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst_any)
    overrun |=> overrun); // R11
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst_any)
    int'(poll_slot) < NUM_SLOTS); // R10
endmodule

// File: tb/smb_status_gate_test.sv
`timescale 1ns/1ps
module smb_status_gate_test;
  localparam int NS = 5;
  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, warm_rst_n = 1'b0, soft_rst = 1'b0, poll_en = 1'b0;
  logic rd_issue = 1'b0, wr_issue = 1'b0, eng_done = 1'b0, eng_nack = 1'b0;
  logic eng_start, rd_valid, wr_done, err, busy, overrun;
  logic [1:0] eng_op;
  logic [2:0] poll_slot;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  smb_status_gate #(.NUM_SLOTS(NS)) uut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .soft_rst(soft_rst),
    .poll_en(poll_en), .rd_issue(rd_issue), .wr_issue(wr_issue), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_start(eng_start), .eng_op(eng_op), .poll_slot(poll_slot),
    .rd_valid(rd_valid), .wr_done(wr_done), .err(err), .busy(busy), .overrun(overrun));

  // inputs {rd,wr,done,nack,pen,soft} | start,op | {rv,wd,err,busy,ovr} after edge | slot
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    {6'b100000, 3'b101, 5'b00010, 3'd0},  // R1 read start
    {6'b000000, 3'b000, 5'b00010, 3'd0},  // R6 held busy
    {6'b001000, 3'b000, 5'b10000, 3'd0},  // R1 read done
    {6'b010000, 3'b110, 5'b10010, 3'd0},  // R2 write start
    {6'b100000, 3'b000, 5'b10011, 3'd0},  // R11 issue while busy
    {6'b001100, 3'b000, 5'b10101, 3'd0},  // R3 manual nack
    {6'b000010, 3'b000, 5'b10101, 3'd0},  // R4 no poll on error
    {6'b010010, 3'b110, 5'b10011, 3'd0},  // R5 R9 manual wins, clears error
    {6'b001010, 3'b000, 5'b11001, 3'd0},  // R2 write done, no poll while busy
    {6'b000010, 3'b111, 5'b11011, 3'd0},  // R9 poll start
    {6'b001000, 3'b000, 5'b11001, 3'd1},  // R10 slot advance
    {6'b000010, 3'b111, 5'b11011, 3'd1},  // R9 poll start
    {6'b001100, 3'b000, 5'b11101, 3'd1},  // R3 poll nack, slot holds
    {6'b000010, 3'b000, 5'b11101, 3'd1},  // R4 frozen
    {6'b100000, 3'b101, 5'b01011, 3'd1},  // R1 R5 read clears rv and err
    {6'b000001, 3'b000, 5'b01001, 3'd1},  // R7 soft reset
    {6'b001000, 3'b000, 5'b01001, 3'd1},  // R6 stray done ignored
    {6'b110000, 3'b101, 5'b01011, 3'd1},  // R9 read beats write
    {6'b001000, 3'b000, 5'b11001, 3'd1}   // R9 write was dropped
  };

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic [4:0] e);
    check({tag, " rd_valid"}, rd_valid, e[4]);
    check({tag, " wr_done"}, wr_done, e[3]);
    check({tag, " err"}, err, e[2]);
    check({tag, " busy"}, busy, e[1]);
    check({tag, " overrun"}, overrun, e[0]);
  endtask

  task automatic step(input logic rd, wr, dn, nk, pe, sr);
    @(negedge clk);
    {rd_issue, wr_issue, eng_done, eng_nack, poll_en, soft_rst} = {rd, wr, dn, nk, pe, sr};
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int exp_slot;
    repeat (3) @(posedge clk);
    #1;
    flags("R12 reset", 5'b00000);
    check("R12 reset slot", poll_slot, 0);
    check("R12 no start in reset", eng_start, 0);
    @(negedge clk); cold_rst_n = 1'b1; warm_rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rd_issue, wr_issue, eng_done, eng_nack, poll_en, soft_rst} = VEC[i][16:11];
      #1;
      check($sformatf("row %0d start", i), eng_start, VEC[i][10]);
      check($sformatf("row %0d op", i), eng_op, VEC[i][9:8]);
      @(posedge clk); #1;
      flags($sformatf("row %0d", i), VEC[i][7:3]);
      check($sformatf("row %0d slot", i), poll_slot, VEC[i][2:0]);
    end

    // R10 wrap at a non power of two
    exp_slot = 1;
    for (int k = 0; k < NS - 1; k++) begin
      step(0, 0, 0, 0, 1, 0);
      step(0, 0, 1, 0, 0, 0);
      exp_slot = (exp_slot + 1) % NS;
      check("R10 slot step", poll_slot, exp_slot);
    end
    check("R10 wrapped to zero", poll_slot, 0);

    // R8 busy survives warm reset, R12 others cleared
    step(1, 0, 0, 0, 0, 0);
    @(negedge clk); rd_issue = 1'b0; warm_rst_n = 1'b0;
    @(posedge clk); #1;
    flags("R8 R12 warm reset", 5'b00010);
    @(negedge clk); warm_rst_n = 1'b1; eng_done = 1'b1;
    @(posedge clk); #1;
    flags("R8 read completes after warm reset", 5'b10000);
    step(1, 0, 0, 0, 0, 0);
    check("R8 busy again", busy, 1);
    @(negedge clk); rd_issue = 1'b0; cold_rst_n = 1'b0;
    @(posedge clk); #1;
    flags("R8 cold reset", 5'b00000);
    @(negedge clk); cold_rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 stays idle", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule